// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block turns the 4-bit transmit nibble stream of a 100 Mb/s media-independent interface into the three-level symbol stream that a twisted-pair line driver sends. It runs on the 125 MHz symbol clock. One nibble is taken every fifth clock. Each nibble becomes a 5-bit code, and the code is shifted out one bit per clock. Each bit is scrambled with an 11-bit keystream, converted to NRZI, and mapped to a three-level MLT3 output code.

The block also builds the frame around the data. While transmit enable is low it fills the line with idle codes. The first two nibbles of a frame are replaced by a start delimiter pair, and two end delimiter codes follow the frame. A nibble flagged with transmit error is sent as an invalid code. The nibble source watches `nib_take` and changes its inputs only in the clock where that strobe is high.

Top module: `fe_tx_encoder`

## Requirements
- R1: While `rst_n` is low, `line_level` is 00 and `nib_take` is low. The code shifted out first after reset is idle (11111).
- R2: A nibble accepted inside a frame, with `tx_er` low and after the two start codes, is sent as its 4B/5B code. The codes for nibble values 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R3: Outside a frame, a nibble slot with `tx_en` low sends the idle code 11111.
- R4: A frame starts at the first slot with `tx_en` high. That slot sends J (11000) and the next slot sends K (10001), whatever `tx_er` and `tx_nib` are in those two slots.
- R5: The first slot with `tx_en` low after a frame has started sends T (01101). The slot after it always sends R (00111), and `tx_en` is ignored in that R slot. This holds even when `tx_en` drops in the K slot.
- R6: A data slot with `tx_en` and `tx_er` both high sends H (00100) in place of the data code.
- R7: `nib_take` is high for one clock in every five, first in the fifth clock after reset. Inputs are sampled at the rising edge that ends that clock. The new code is sent most significant bit first, starting in the next clock.
- R8: The scrambler is an 11-bit register with polynomial x^11 + x^9 + 1. It is loaded with SEED at reset and shifts left every clock; the new bit is bit 10 XOR bit 8. Its bit 10 is the keystream bit, and each code bit is XORed with it. The keystream never reaches the all-zero state and repeats every 2047 bits.
- R9: The NRZI stage toggles on each scrambled 1 and holds on a 0. On each NRZI toggle, the MLT3 output steps through the cycle 0, +1, 0, -1. `line_level` encodes these levels as 00, 01 and 11. A code bit present in clock n shows up on `line_level` after the third rising edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable for the current nibble slot |
| tx_er | input | 1 | Transmit error for the current nibble slot |
| tx_nib | input | 4 | Transmit data nibble |
| nib_take | output | 1 | High in the clock whose closing edge samples the inputs |
| line_level | output | 2 | MLT3 level: 00 zero, 01 plus one, 11 minus one |

## Verification
The bench builds the block with the default 11-bit register width and tap 9, but with SEED overridden to 0x3A5. A seed other than the default shows that reset really loads the parameter. It also sends a long idle stretch of more than 2047 code bits, so a full keystream period passes through the comparison. The polynomial is then checked end to end, not only over its first bits. Frames cover a full data run, errors in data and in the K slot, `tx_en` high during the R slot, and a one-nibble frame.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t SYM_IDLE = 5'b11111;
    localparam sym_t SYM_J    = 5'b11000;
    localparam sym_t SYM_K    = 5'b10001;
    localparam sym_t SYM_T    = 5'b01101;
    localparam sym_t SYM_R    = 5'b00111;
    localparam sym_t SYM_H    = 5'b00100;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_K,
        FR_BODY,
        FR_R
    } frm_e;
endpackage

// File: rtl/fe_tx_sym_map.sv
module fe_tx_sym_map
    import fe_tx_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    input  logic             err,
    output sym_t             sym
);
    sym_t data_sym;

    always_comb begin
        unique case (nib)
            4'h0: data_sym = 5'b11110;
            4'h1: data_sym = 5'b01001;
            4'h2: data_sym = 5'b10100;
            4'h3: data_sym = 5'b10101;
            4'h4: data_sym = 5'b01010;
            4'h5: data_sym = 5'b01011;
            4'h6: data_sym = 5'b01110;
            4'h7: data_sym = 5'b01111;
            4'h8: data_sym = 5'b10010;
            4'h9: data_sym = 5'b10011;
            4'hA: data_sym = 5'b10110;
            4'hB: data_sym = 5'b10111;
            4'hC: data_sym = 5'b11010;
            4'hD: data_sym = 5'b11011;
            4'hE: data_sym = 5'b11100;
            4'hF: data_sym = 5'b11101;
        endcase
    end

    assign sym = err ? SYM_H : data_sym;
endmodule

// File: rtl/fe_tx_framer.sv
module fe_tx_framer
    import fe_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_er,
    input  sym_t data_sym,
    output logic nib_take,
    output logic code_bit
);
    localparam int CNT_W = $clog2(SYM_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        frm_e             st;
        sym_t             sh;
    } frm_s;

    frm_s frm_d, frm_q;
    logic tick;

    assign tick     = (frm_q.cnt == CNT_W'(SYM_W - 1));
    assign nib_take = tick;
    assign code_bit = frm_q.sh[SYM_W-1];

    always_comb begin
        frm_d = frm_q;
        if (tick) begin
            frm_d.cnt = '0;
            unique case (frm_q.st)
                FR_IDLE: begin
                    if (tx_en) begin
                        frm_d.sh = SYM_J;
                        frm_d.st = FR_K;
                    end else begin
                        frm_d.sh = SYM_IDLE;
                    end
                end
                FR_K: begin
                    if (tx_en) begin
                        frm_d.sh = SYM_K;
                        frm_d.st = FR_BODY;
                    end else begin
                        frm_d.sh = SYM_T;
                        frm_d.st = FR_R;
                    end
                end
                FR_BODY: begin
                    if (tx_en) begin
                        frm_d.sh = data_sym;
                    end else begin
                        frm_d.sh = SYM_T;
                        frm_d.st = FR_R;
                    end
                end
                FR_R: begin
                    frm_d.sh = SYM_R;
                    frm_d.st = FR_IDLE;
                end
            endcase
        end else begin
            frm_d.cnt = frm_q.cnt + CNT_W'(1);
            frm_d.sh  = {frm_q.sh[SYM_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '{cnt: '0, st: FR_IDLE, sh: SYM_IDLE};
        end else begin
            frm_q <= frm_d;
        end
    end

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q.cnt < CNT_W'(SYM_W));
    // R7
    take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_take |=> !nib_take);
    // R3
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_take && frm_q.st == FR_IDLE && !tx_en) |=> frm_q.sh == SYM_IDLE);
    // R4
    start_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_take && frm_q.st == FR_IDLE && tx_en) |=> (frm_q.sh == SYM_J && frm_q.st == FR_K));
    // R5
    end_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_take && frm_q.st == FR_R) |=> (frm_q.sh == SYM_R && frm_q.st == FR_IDLE));
    // R6
    err_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_take && frm_q.st == FR_BODY && tx_en && tx_er) |=> frm_q.sh == SYM_H);
endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler #(
    parameter int               LFSR_W   = 11,
    parameter int               LFSR_TAP = 9,
    parameter logic [LFSR_W-1:0] SEED    = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic plain_bit,
    output logic scr_bit
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic              scr;
    } scr_s;

    scr_s scr_d, scr_q;

    always_comb begin
        scr_d      = scr_q;
        scr_d.lfsr = {scr_q.lfsr[LFSR_W-2:0], scr_q.lfsr[LFSR_W-1] ^ scr_q.lfsr[LFSR_TAP-1]};
        scr_d.scr  = plain_bit ^ scr_q.lfsr[LFSR_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scr_q <= '{lfsr: SEED, scr: 1'b0};
        end else begin
            scr_q <= scr_d;
        end
    end

    assign scr_bit = scr_q.scr;

    // R8
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scr_q.lfsr != '0);
    // R8
    scr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> scr_q.scr == ($past(plain_bit) ^ $past(scr_q.lfsr[LFSR_W-1])));
endmodule

// File: rtl/fe_tx_line_coder.sv
module fe_tx_line_coder
    import fe_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scr_bit,
    output lvl_e level
);
    typedef struct packed {
        logic       nrzi;
        logic       nrzi_prev;
        logic [1:0] ph;
    } lc_s;

    lc_s lc_d, lc_q;

    always_comb begin
        lc_d           = lc_q;
        lc_d.nrzi      = lc_q.nrzi ^ scr_bit;
        lc_d.nrzi_prev = lc_q.nrzi;
        lc_d.ph        = lc_q.ph + {1'b0, lc_q.nrzi ^ lc_q.nrzi_prev};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lc_q <= '0;
        end else begin
            lc_q <= lc_d;
        end
    end

    always_comb begin
        unique case (lc_q.ph)
            2'd1:    level = LVL_POS;
            2'd3:    level = LVL_NEG;
            default: level = LVL_ZERO;
        endcase
    end

    // R9
    nrzi_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scr_bit) |-> (lc_q.nrzi != $past(lc_q.nrzi)));
    // R9
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> (level == LVL_ZERO || $past(level) == LVL_ZERO));
    // R9
    level_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(lc_q.nrzi) != $past(lc_q.nrzi_prev)));
endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder
    import fe_tx_pkg::*;
#(
    parameter int                LFSR_W   = 11,
    parameter int                LFSR_TAP = 9,
    parameter logic [LFSR_W-1:0] SEED     = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] tx_nib,
    output logic             nib_take,
    output logic [1:0]       line_level
);
    sym_t data_sym;
    logic code_bit;
    logic scr_bit;
    lvl_e level;

    fe_tx_sym_map u_map (
        .nib (tx_nib),
        .err (tx_er),
        .sym (data_sym)
    );

    fe_tx_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .tx_er    (tx_er),
        .data_sym (data_sym),
        .nib_take (nib_take),
        .code_bit (code_bit)
    );

    fe_tx_scrambler #(
        .LFSR_W   (LFSR_W),
        .LFSR_TAP (LFSR_TAP),
        .SEED     (SEED)
    ) u_scr (
        .clk       (clk),
        .rst_n     (rst_n),
        .plain_bit (code_bit),
        .scr_bit   (scr_bit)
    );

    fe_tx_line_coder u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .scr_bit (scr_bit),
        .level   (level)
    );

    assign line_level = level;

    // R1
    reset_level_chk: assert property (@(posedge clk)
        !rst_n |-> (line_level == 2'b00 && !nib_take));
endmodule

// File: tb/fe_tx_encoder_tb.sv
module fe_tx_encoder_tb;
    localparam logic [10:0] TB_SEED = 11'h3A5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] tx_nib = 4'h0;
    logic       nib_take;
    logic [1:0] line_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fe_tx_encoder #(.SEED(TB_SEED)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .tx_er      (tx_er),
        .tx_nib     (tx_nib),
        .nib_take   (nib_take),
        .line_level (line_level)
    );

    // stimulus entries: bit5 = enable, bit4 = error, bits3:0 = nibble
    int stim[$];
    int bits_q[$];
    int kind_q[$];
    int dly_s[$];
    int dly_k[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put(input int en, input int er, input int d);
        stim.push_back((en << 5) | (er << 4) | d);
    endtask

    function automatic int code_of(input int n);
        int tab[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                        5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                        5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return tab[n];
    endfunction

    function automatic string req_of(input int k);
        case (k)
            0: return "R3 idle";
            1: return "R4 start";
            2: return "R5 end";
            3: return "R6 error";
            default: return "R2 data";
        endcase
    endfunction

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7 actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int lf;
        int phase;
        int in_frame;
        int nib_idx;
        int tail;
        int last_kind;
        int total;

        // idle lead-in
        for (int i = 0; i < 6; i++) put(0, 0, 0);
        // frame A: preamble, delimiter nibble, full data sweep
        for (int i = 0; i < 4; i++) put(1, 0, 5);
        put(1, 0, 4'hD);
        for (int i = 0; i < 16; i++) put(1, 0, i);
        for (int i = 0; i < 8; i++) put(1, 0, (i * 7) & 15);
        for (int i = 0; i < 5; i++) put(0, 0, 0);
        // frame B: error in K slot (ignored), errors in data, enable during R slot
        put(1, 0, 5);
        put(1, 1, 5);
        put(1, 0, 4'hD);
        for (int i = 0; i < 12; i++) put(1, (i == 3 || i == 9) ? 1 : 0, 15 - i);
        put(0, 0, 0);
        put(1, 0, 9);
        // frame C follows immediately, enable high right after the R slot
        put(1, 0, 5);
        put(1, 0, 5);
        put(1, 1, 2);
        put(0, 1, 3);
        put(0, 0, 0);
        put(0, 0, 0);
        // frame D: single nibble, enable drops in the K slot
        put(1, 0, 1);
        put(0, 0, 0);
        put(0, 0, 0);
        // long idle stretch, more than one keystream period
        for (int i = 0; i < 500; i++) put(0, 0, 0);

        total = (stim.size() + 4) * 5;

        // reset phase, R1
        repeat (3) @(negedge clk);
        chk(line_level == 2'b00, "R1 level in reset", line_level, 0);
        chk(nib_take == 1'b0, "R1 take in reset", nib_take, 0);
        rst_n = 1'b1;

        lf = TB_SEED;
        phase = 0;
        in_frame = 0;
        nib_idx = 0;
        tail = 0;
        last_kind = 0;
        for (int b = 0; b < 5; b++) begin
            bits_q.push_back(1);
            kind_q.push_back(0);
        end

        for (int i = 0; i < total; i++) begin
            int exp_lvl;
            int exp_take;
            int bit_now;
            int key;
            int s;
            exp_lvl  = (phase == 1) ? 1 : (phase == 3) ? 3 : 0;
            exp_take = (i % 5 == 4) ? 1 : 0;
            chk(int'(line_level) == exp_lvl, $sformatf("%s R9 level", req_of(last_kind)),
                line_level, exp_lvl);
            chk(int'(nib_take) == exp_take, "R7 take strobe", nib_take, exp_take);

            if (exp_take == 1) begin
                int e;
                int en;
                int er;
                int d;
                int code;
                int kind;
                e = (stim.size() > 0) ? stim.pop_front() : 0;
                en = (e >> 5) & 1;
                er = (e >> 4) & 1;
                d  = e & 15;
                tx_en  = en[0];
                tx_er  = er[0];
                tx_nib = d[3:0];
                if (tail == 1) begin
                    code = 5'b00111; kind = 2; tail = 0;
                end else if (in_frame == 0) begin
                    if (en == 1) begin
                        code = 5'b11000; kind = 1; in_frame = 1; nib_idx = 1;
                    end else begin
                        code = 5'b11111; kind = 0;
                    end
                end else if (en == 0) begin
                    code = 5'b01101; kind = 2; in_frame = 0; tail = 1;
                end else if (nib_idx == 1) begin
                    code = 5'b10001; kind = 1; nib_idx = 2;
                end else if (er == 1) begin
                    code = 5'b00100; kind = 3;
                end else begin
                    code = code_of(d); kind = 4;
                end
                for (int b = 4; b >= 0; b--) begin
                    bits_q.push_back((code >> b) & 1);
                    kind_q.push_back(kind);
                end
            end

            // advance the reference by one clock (R8 keystream, R9 line code)
            bit_now = bits_q.pop_front();
            key = (lf >> 10) & 1;
            s = bit_now ^ key;
            lf = ((lf << 1) & 11'h7FF) | (((lf >> 10) ^ (lf >> 8)) & 1);
            dly_s.push_back(s);
            dly_k.push_back(kind_q.pop_front());
            if (dly_s.size() == 3) begin
                phase = (phase + dly_s.pop_front()) % 4;
                last_kind = dly_k.pop_front();
            end

            @(negedge clk);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule